// File: doc/BRIEF.md
# Power Button Debouncer with Interrupt

This block conditions an active-low power button. The button pulls the pin to ground while it is held. The raw pin first passes through a synchronizer. A debouncer then accepts a new level only after the pin has held that level for a set number of ticks of a 1 ms timebase. The press direction (high to low) and the release direction (low to high) use separate times.

The release time is fixed at 30 ticks. A 2-bit setting chooses the press time: 30, 60, 250 or 1000 ticks. The block has three outputs:
- a live sense bit that reads 1 while the debounced button is held;
- a sticky interrupt flag that records every debounced press and every debounced release;
- a one-cycle turn-on request, raised when a debounced press occurs while the system is off and the supply is valid.

Software clears the flag directly. The flag also clears each time the system enters the Off state. The interrupt mask gates only the interrupt output. It does not affect the flag or the turn-on request.

Top module: `pb_button_ctrl`

## Requirements
- R1: After reset the debounced level is "released": `sense` is 0, `irq_flag` is 0, `irq_out` is 0 and `wake_req` is 0. Afterwards `sense` is 1 exactly while the debounced level is "pressed" (pin low).
- R2: A press is accepted once the synchronized pin has been low on N consecutive ticks, where N is 30, 60, 250 or 1000 for `fall_sel` values 0, 1, 2 and 3. After N-1 such ticks `sense` is still 0.
- R3: A release is accepted after 30 consecutive high ticks, whatever the value of `fall_sel`.
- R4: If the pin returns to the debounced level before the count completes, the count restarts from zero and no event, flag or turn-on request results.
- R5: `irq_flag` is set on every accepted press and on every accepted release.
- R6: A one-cycle `irq_clr` pulse clears `irq_flag`. If a new edge is accepted in the same cycle, the set takes priority.
- R7: `irq_flag` is cleared in the cycle after `sys_off` rises from 0 to 1. A set in that same cycle takes priority.
- R8: `irq_out` equals `irq_flag` AND NOT `irq_mask`. The mask does not change `irq_flag` or `wake_req`.
- R9: `wake_req` pulses high for exactly one cycle after an accepted press while `sys_off` and `supply_ok` are both 1. Releases never raise it, and it stays 0 when either condition is 0.
- R10: An accepted press sets `irq_flag` even when `sys_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_pin_n | input | 1 | Raw button pin, low when pressed, asynchronous |
| tick | input | 1 | One-cycle pulse, once per millisecond |
| fall_sel | input | 2 | Press debounce selector (0:30, 1:60, 2:250, 3:1000 ticks) |
| irq_mask | input | 1 | 1 blocks `irq_out` |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| sys_off | input | 1 | 1 while the system is in the Off state |
| supply_ok | input | 1 | Supply valid, qualifies the turn-on request |
| sense | output | 1 | Debounced level, 1 = pressed |
| irq_flag | output | 1 | Sticky edge interrupt flag |
| irq_out | output | 1 | Interrupt flag after the mask |
| wake_req | output | 1 | One-cycle turn-on request |

## Verification
A pin change reaches the debouncer after two synchronizer cycles. `sense`, `irq_flag` and `wake_req` all update on the clock edge that samples the completing tick, so the three results are due in the same cycle.

The bench drives the pin and `tick` on falling clock edges. It waits four cycles after each pin change before issuing ticks, so the synchronizer has settled. It then checks the outputs after tick N-1 (no change yet) and again two cycles after tick N (change taken).

Turn-on pulses are counted by a monitor that samples on falling edges. The effect of a clear is checked two cycles after its pulse.

// File: rtl/pb_pkg.sv
package pb_pkg;

    parameter int unsigned RISE_TICKS = 30;
    parameter int unsigned FALL_T0    = 30;
    parameter int unsigned FALL_T1    = 60;
    parameter int unsigned FALL_T2    = 250;
    parameter int unsigned FALL_T3    = 1000;
    localparam int unsigned MAX_TICKS = FALL_T3;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic fire;     // an edge was accepted this cycle
        logic pressed;  // new level is pressed
    } edge_evt_t;

    function automatic cnt_t fall_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    return cnt_t'(FALL_T0);
            2'd1:    return cnt_t'(FALL_T1);
            2'd2:    return cnt_t'(FALL_T2);
            default: return cnt_t'(FALL_T3);
        endcase
    endfunction

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else if (g == 0) chain[g] <= din;
                else chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pb_debounce.sv
module pb_debounce
    import pb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s,
    input  logic       tick,
    input  logic [1:0] fall_sel,
    output logic       level,
    output edge_evt_t  evt
);
    cnt_t cnt;
    cnt_t limit;
    logic differ;

    assign differ = (pin_s != level);
    assign limit  = pin_s ? cnt_t'(RISE_TICKS) : fall_limit(fall_sel);

    always_comb begin
        evt.fire    = differ && tick && (cnt >= limit - cnt_t'(1));
        evt.pressed = !pin_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b1;
            cnt   <= '0;
        end else if (!differ) begin
            cnt <= '0;
        end else if (tick) begin
            if (evt.fire) begin
                level <= pin_s;
                cnt   <= '0;
            end else begin
                cnt <= cnt + cnt_t'(1);
            end
        end
    end

    // R2
    level_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(level));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < cnt_t'(MAX_TICKS));

    // R4
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !differ |=> cnt == '0);
endmodule

// File: rtl/pb_irq.sv
module pb_irq
    import pb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_evt_t evt,
    input  logic      irq_clr,
    input  logic      sys_off,
    input  logic      supply_ok,
    output logic      flag,
    output logic      wake
);
    logic off_q;
    logic off_entry;

    assign off_entry = sys_off && !off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            wake  <= 1'b0;
            off_q <= 1'b0;
        end else begin
            off_q <= sys_off;
            if (evt.fire)                   flag <= 1'b1;
            else if (irq_clr || off_entry)  flag <= 1'b0;
            wake <= evt.fire && evt.pressed && sys_off && supply_ok;
        end
    end

    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(evt.fire));

    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(irq_clr || off_entry));

    // R9
    wake_qual_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(sys_off && supply_ok && evt.pressed));

    // R9
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);
endmodule

// File: rtl/pb_button_ctrl.sv
module pb_button_ctrl
    import pb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_pin_n,
    input  logic       tick,
    input  logic [1:0] fall_sel,
    input  logic       irq_mask,
    input  logic       irq_clr,
    input  logic       sys_off,
    input  logic       supply_ok,
    output logic       sense,
    output logic       irq_flag,
    output logic       irq_out,
    output logic       wake_req
);
    logic      pin_s;
    logic      level;
    edge_evt_t evt;

    pb_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .din(btn_pin_n), .dout(pin_s)
    );

    pb_debounce i_deb (
        .clk(clk), .rst(rst), .pin_s(pin_s), .tick(tick),
        .fall_sel(fall_sel), .level(level), .evt(evt)
    );

    pb_irq i_irq (
        .clk(clk), .rst(rst), .evt(evt), .irq_clr(irq_clr),
        .sys_off(sys_off), .supply_ok(supply_ok),
        .flag(irq_flag), .wake(wake_req)
    );

    assign sense   = !level;
    assign irq_out = irq_flag && !irq_mask;

    // R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_mask |-> !irq_out);

    // R1
    sense_move_chk: assert property (@(posedge clk) disable iff (rst)
        (sense != $past(sense)) |-> $past(evt.fire));
endmodule

// File: tb/test_pb_button_ctrl.sv
module test_pb_button_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_pin_n = 1'b1;
    logic tick = 1'b0;
    logic [1:0] fall_sel = 2'd0;
    logic irq_mask = 1'b0;
    logic irq_clr = 1'b0;
    logic sys_off = 1'b0;
    logic supply_ok = 1'b1;
    logic sense, irq_flag, irq_out, wake_req;

    int tests = 0;
    int fails = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pb_button_ctrl i_pb_button_ctrl (
        .clk(clk), .rst(rst), .btn_pin_n(btn_pin_n), .tick(tick),
        .fall_sel(fall_sel), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .sys_off(sys_off), .supply_ok(supply_ok), .sense(sense),
        .irq_flag(irq_flag), .irq_out(irq_out), .wake_req(wake_req)
    );

    always @(negedge clk) if (!rst && wake_req) wake_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            cyc(2);
        end
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk) btn_pin_n = v;
        cyc(4);
    endtask

    task automatic pulse_clr;
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        cyc(2);
    endtask

    task automatic do_release;
        set_pin(1'b1);
        ticks(30);
        cyc(2);
        pulse_clr();
    endtask

    task automatic t_reset;
        check(sense == 0, "R1 sense", sense, 0);
        check(irq_flag == 0, "R1 flag", irq_flag, 0);
        check(irq_out == 0 && wake_req == 0, "R1 out/wake", irq_out, 0);
    endtask

    task automatic t_fall(input logic [1:0] sel, input int n);
        int w0;
        fall_sel = sel;
        w0 = wake_cnt;
        set_pin(1'b0);
        ticks(n - 1);
        check(sense == 0, "R2 early", sense, 0);
        ticks(1);
        cyc(1);
        check(sense == 1, "R2 accepted", sense, 1);
        check(irq_flag == 1, "R5 press flag", irq_flag, 1);
        check(wake_cnt == w0, "R9 no wake when on", wake_cnt - w0, 0);
        pulse_clr();
        check(irq_flag == 0, "R6 clear", irq_flag, 0);
        fall_sel = 2'd3;
        set_pin(1'b1);
        ticks(29);
        check(sense == 1, "R3 early", sense, 1);
        ticks(1);
        cyc(1);
        check(sense == 0, "R3 accepted", sense, 0);
        check(irq_flag == 1, "R5 release flag", irq_flag, 1);
        pulse_clr();
    endtask

    task automatic t_glitch;
        fall_sel = 2'd0;
        set_pin(1'b0);
        ticks(20);
        set_pin(1'b1);
        ticks(2);
        check(sense == 0 && irq_flag == 0, "R4 no event", irq_flag, 0);
        set_pin(1'b0);
        ticks(29);
        check(sense == 0, "R4 restarted", sense, 0);
        ticks(1);
        cyc(1);
        check(sense == 1, "R4 then accepted", sense, 1);
        do_release();
    endtask

    task automatic t_wake_mask;
        int w0;
        fall_sel = 2'd0;
        irq_mask = 1'b1;
        @(negedge clk) sys_off = 1'b1;
        cyc(2);
        w0 = wake_cnt;
        set_pin(1'b0);
        ticks(30);
        cyc(2);
        check(wake_cnt - w0 == 1, "R9 one wake pulse", wake_cnt - w0, 1);
        check(irq_flag == 1, "R8 flag under mask", irq_flag, 1);
        check(irq_out == 0, "R8 masked out", irq_out, 0);
        irq_mask = 1'b0;
        cyc(1);
        check(irq_out == 1, "R8 unmasked out", irq_out, 1);
        w0 = wake_cnt;
        set_pin(1'b1);
        ticks(30);
        cyc(2);
        check(wake_cnt == w0, "R9 no wake on release", wake_cnt - w0, 0);
        @(negedge clk) sys_off = 1'b0;
        cyc(2);
        check(irq_flag == 1, "R7 flag kept on exit", irq_flag, 1);
        @(negedge clk) sys_off = 1'b1;
        cyc(2);
        check(irq_flag == 0, "R7 cleared on Off entry", irq_flag, 0);
        supply_ok = 1'b0;
        w0 = wake_cnt;
        set_pin(1'b0);
        ticks(30);
        cyc(2);
        check(wake_cnt == w0, "R9 no wake without supply", wake_cnt - w0, 0);
        supply_ok = 1'b1;
        set_pin(1'b1);
        ticks(30);
        cyc(2);
        @(negedge clk) sys_off = 1'b0;
        pulse_clr();
    endtask

    task automatic t_on_press;
        fall_sel = 2'd0;
        set_pin(1'b0);
        ticks(30);
        cyc(1);
        check(irq_flag == 1, "R10 flag while on", irq_flag, 1);
        do_release();
    endtask

    task automatic t_set_wins;
        fall_sel = 2'd0;
        set_pin(1'b0);
        ticks(29);
        @(negedge clk) begin tick = 1'b1; irq_clr = 1'b1; end
        @(negedge clk) begin tick = 1'b0; irq_clr = 1'b0; end
        cyc(1);
        check(irq_flag == 1, "R6 set beats clear", irq_flag, 1);
        do_release();
    endtask

    initial begin
        cyc(3);
        @(negedge clk) rst = 1'b0;
        cyc(1);
        t_reset();
        t_fall(2'd0, 30);
        t_fall(2'd1, 60);
        t_fall(2'd2, 250);
        t_fall(2'd3, 1000);
        t_glitch();
        t_wake_mask();
        t_on_press();
        t_set_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule